// File: doc/BRIEF.md
# Prioritized 64-Source Interrupt Controller

This block gathers 64 level-sensitive interrupt request lines and presents a single winner to the CPU. It presents that winner as an interrupt level and a vector number. Each source has its own mask bit and an 8-bit priority byte. A source is switched on by giving it a nonzero priority byte and switched off by writing zero to that byte. Among the sources that are pending, switched on and unmasked, the one with the highest priority byte wins. On equal priority the source with the larger index wins.

Software talks to the block through a byte-addressed register port. The port has a write strobe, a read strobe, an 8-bit offset and 32-bit data. Software can read the pending, mask and forced bits as two 32-bit halves each, and can rewrite either half of the mask. It can program and read back every priority byte, and can fetch the current vector from an acknowledge offset. When nothing is eligible the outputs show level 0 and a fixed spurious vector of 24. A write to an offset the block does not decode has no effect and produces a one-cycle error pulse.

Top module: `intc_prio64`

## Requirements
- R1: At every clock edge the 64-bit pending register loads `irq_i`. Bits 63:32 read at offset 0x00 and bits 31:0 read at offset 0x04.
- R2: Source n is eligible only when its pending bit is 1, its enable bit is 1 and its mask bit is 0. A masked or disabled source never drives the outputs.
- R3: A write to offset 0x40+n (n = 0..63) stores `wdata_i[7:0]` as the priority byte of source n. A zero byte clears the source's enable and a nonzero byte sets it. A read at 0x40+n returns the byte zero-extended.
- R4: The eligible source with the highest priority byte wins. When priority bytes are equal, the higher source index wins.
- R5: `level_o` is the winner's priority byte and `vector_o` is the winner's index + 64. With no eligible source, `level_o` is 0 and `vector_o` is 24.
- R6: The mask reads as bits 63:32 at 0x08 and bits 31:0 at 0x0C. A write to 0x08 replaces only bits 63:32 and a write to 0x0C replaces only bits 31:0. A mask bit of 1 blocks its source.
- R7: Writes to 0x00 and 0x04 change no state and raise no error.
- R8: A read at 0xE0 returns the current `vector_o`. The forced halves at 0x10/0x14 always read zero. Every other offset, including 0xE1–0xE7, reads zero, and `rdata_o` is zero while `rd_i` is low.
- R9: After reset the mask is all ones, pending, enables and priority bytes are zero, `level_o` is 0, `vector_o` is 24 and `err_o` is 0.
- R10: A write to any offset other than 0x00, 0x04, 0x08, 0x0C or 0x40–0x7F changes no state. It makes `err_o` high for exactly the one cycle after the write edge.
- R11: `level_o` and `vector_o` are registered. They reflect the pending, mask and priority state one clock edge after that state changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from offset |
| err_o | output | 1 | One-cycle pulse after a write to an undecoded offset |
| irq_i | input | 64 | Level-sensitive request lines |
| level_o | output | 8 | Priority byte of the winning source, 0 when idle |
| vector_o | output | 8 | Winner index + 64, or 24 when idle |

## Verification
The bench builds the block with its default parameters: 64 sources, 8-bit priority bytes and 32-bit data. At these values both mask halves, the top source 63 with the largest vector 127, and the full 0x40–0x7F priority window can be reached. The vector table sets sources to equal and to differing priorities, and includes a disabled source. This exercises tie-breaking toward the higher index and the drop to the spurious vector. Directed steps cover reset values, half-mask writes, ignored pending writes, error pulses and the one-edge output latency.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned VEC_BASE  = 64;
  localparam int unsigned SPUR_VEC  = 24;
  localparam logic [7:0]  OFS_PND_H = 8'h00;
  localparam logic [7:0]  OFS_PND_L = 8'h04;
  localparam logic [7:0]  OFS_MSK_H = 8'h08;
  localparam logic [7:0]  OFS_MSK_L = 8'h0C;
  localparam logic [7:0]  OFS_FRC_H = 8'h10;
  localparam logic [7:0]  OFS_FRC_L = 8'h14;
  localparam logic [7:0]  OFS_LVL   = 8'h40;
  localparam logic [7:0]  OFS_ACK   = 8'hE0;
endpackage

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int unsigned N_SRC  = 64,
  parameter int unsigned LVL_W  = 8,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  input  logic [N_SRC-1:0]              irq_i,
  output logic [N_SRC-1:0]              pend_o,
  output logic [N_SRC-1:0]              mask_o,
  output logic [N_SRC-1:0]              en_o,
  output logic [N_SRC-1:0][LVL_W-1:0]   lvl_o,
  output logic                          err_o
);
  localparam int unsigned HALF = N_SRC / 2;

  logic hit_msk_h, hit_msk_l, hit_pnd, hit_lvl, bad_wr;

  assign hit_msk_h = (addr_i == ADDR_W'(OFS_MSK_H));
  assign hit_msk_l = (addr_i == ADDR_W'(OFS_MSK_L));
  assign hit_pnd   = (addr_i == ADDR_W'(OFS_PND_H)) || (addr_i == ADDR_W'(OFS_PND_L));
  assign hit_lvl   = (addr_i >= ADDR_W'(OFS_LVL)) && (addr_i < ADDR_W'(OFS_LVL + N_SRC));
  assign bad_wr    = wr_i && !(hit_msk_h || hit_msk_l || hit_pnd || hit_lvl);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= '0;
      mask_o <= '1;
      err_o  <= 1'b0;
    end else begin
      pend_o <= irq_i;
      err_o  <= bad_wr;
      if (wr_i && hit_msk_h) mask_o[N_SRC-1:HALF] <= wdata_i[HALF-1:0];
      if (wr_i && hit_msk_l) mask_o[HALF-1:0]     <= wdata_i[HALF-1:0];
    end
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_lvl
    logic sel;
    assign sel = wr_i && (addr_i == ADDR_W'(OFS_LVL + g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lvl_o[g] <= '0;
        en_o[g]  <= 1'b0;
      end else if (sel) begin
        lvl_o[g] <= wdata_i[LVL_W-1:0];
        en_o[g]  <= |wdata_i[LVL_W-1:0];
      end
    end
  end
endmodule

// File: rtl/intc_arb.sv
module intc_arb #(
  parameter int unsigned N_SRC = 64,
  parameter int unsigned LVL_W = 8,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]            elig_i,
  input  logic [N_SRC-1:0][LVL_W-1:0] lvl_i,
  output logic                        win_v_o,
  output logic [LVL_W-1:0]            win_lvl_o,
  output logic [IDX_W-1:0]            win_idx_o
);
  localparam int unsigned NODES = 2 * N_SRC - 1;

  logic             nv [NODES];
  logic [LVL_W-1:0] nl [NODES];
  logic [IDX_W-1:0] ni [NODES];

  for (genvar g = 0; g < N_SRC; g++) begin : g_leaf
    assign nv[N_SRC-1+g] = elig_i[g];
    assign nl[N_SRC-1+g] = lvl_i[g];
    assign ni[N_SRC-1+g] = IDX_W'(g);
  end

  // left child holds lower indices; ties go right
  for (genvar k = 0; k < N_SRC - 1; k++) begin : g_node
    logic take_hi;
    assign take_hi = nv[2*k+2] && (!nv[2*k+1] || (nl[2*k+2] >= nl[2*k+1]));
    assign nv[k]   = nv[2*k+1] | nv[2*k+2];
    assign nl[k]   = take_hi ? nl[2*k+2] : nl[2*k+1];
    assign ni[k]   = take_hi ? ni[2*k+2] : ni[2*k+1];
  end

  assign win_v_o   = nv[0];
  assign win_lvl_o = nl[0];
  assign win_idx_o = ni[0];
endmodule

// File: rtl/intc_rdmux.sv
module intc_rdmux
  import intc_pkg::*;
#(
  parameter int unsigned N_SRC  = 64,
  parameter int unsigned LVL_W  = 8,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned VEC_W  = 8
) (
  input  logic                        rd_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [N_SRC-1:0]            pend_i,
  input  logic [N_SRC-1:0]            mask_i,
  input  logic [N_SRC-1:0][LVL_W-1:0] lvl_i,
  input  logic [VEC_W-1:0]            vec_i,
  output logic [DATA_W-1:0]           rdata_o
);
  localparam int unsigned HALF  = N_SRC / 2;
  localparam int unsigned IDX_W = $clog2(N_SRC);

  logic [ADDR_W-1:0] lvl_ofs;
  assign lvl_ofs = addr_i - ADDR_W'(OFS_LVL);

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if ((addr_i >= ADDR_W'(OFS_LVL)) && (addr_i < ADDR_W'(OFS_LVL + N_SRC))) begin
        rdata_o = DATA_W'(lvl_i[lvl_ofs[IDX_W-1:0]]);
      end else begin
        case (addr_i)
          ADDR_W'(OFS_PND_H): rdata_o = DATA_W'(pend_i[N_SRC-1:HALF]);
          ADDR_W'(OFS_PND_L): rdata_o = DATA_W'(pend_i[HALF-1:0]);
          ADDR_W'(OFS_MSK_H): rdata_o = DATA_W'(mask_i[N_SRC-1:HALF]);
          ADDR_W'(OFS_MSK_L): rdata_o = DATA_W'(mask_i[HALF-1:0]);
          ADDR_W'(OFS_ACK):   rdata_o = DATA_W'(vec_i);
          default:            rdata_o = '0;  // forced halves and all else
        endcase
      end
    end
  end
endmodule

// File: rtl/intc_prio64.sv
module intc_prio64
  import intc_pkg::*;
#(
  parameter int unsigned N_SRC  = 64,
  parameter int unsigned LVL_W  = 8,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned VEC_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  input  logic [N_SRC-1:0]  irq_i,
  output logic [LVL_W-1:0]  level_o,
  output logic [VEC_W-1:0]  vector_o
);
  localparam int unsigned IDX_W = $clog2(N_SRC);

  logic [N_SRC-1:0]            pend_q, mask_q, en_q, elig;
  logic [N_SRC-1:0][LVL_W-1:0] lvl_q;
  logic                        win_v;
  logic [LVL_W-1:0]            win_lvl;
  logic [IDX_W-1:0]            win_idx;

  intc_regs #(
    .N_SRC(N_SRC), .LVL_W(LVL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) i_regs (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i, .irq_i,
    .pend_o(pend_q), .mask_o(mask_q), .en_o(en_q), .lvl_o(lvl_q), .err_o(err_o)
  );

  assign elig = pend_q & en_q & ~mask_q;

  intc_arb #(.N_SRC(N_SRC), .LVL_W(LVL_W)) i_arb (
    .elig_i(elig), .lvl_i(lvl_q),
    .win_v_o(win_v), .win_lvl_o(win_lvl), .win_idx_o(win_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_o  <= '0;
      vector_o <= VEC_W'(SPUR_VEC);
    end else if (win_v) begin
      level_o  <= win_lvl;
      vector_o <= VEC_W'(VEC_BASE) + VEC_W'(win_idx);
    end else begin
      level_o  <= '0;
      vector_o <= VEC_W'(SPUR_VEC);
    end
  end

  intc_rdmux #(
    .N_SRC(N_SRC), .LVL_W(LVL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .VEC_W(VEC_W)
  ) i_rdmux (
    .rd_i, .addr_i, .pend_i(pend_q), .mask_i(mask_q), .lvl_i(lvl_q),
    .vec_i(vector_o), .rdata_o(rdata_o)
  );
endmodule

// File: rtl/intc_prio64_chk.sv
module intc_prio64_chk #(
  parameter int unsigned N_SRC  = 64,
  parameter int unsigned LVL_W  = 8,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned VEC_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              err_o,
  input logic [LVL_W-1:0]  level_o,
  input logic [VEC_W-1:0]  vector_o,
  input logic [N_SRC-1:0]  mask_q
);
  localparam int unsigned HALF = N_SRC / 2;

  p_idle_vec_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o == '0) |-> (vector_o == VEC_W'(24)));

  p_vec_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o != '0) |-> (vector_o >= VEC_W'(64)));

  p_err_cause_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(wr_i));

  p_pend_wr_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && (addr_i == ADDR_W'(8'h00) || addr_i == ADDR_W'(8'h04))) |=> !err_o);

  p_mask_lo_wr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADDR_W'(8'h0C)) |=> $stable(mask_q[N_SRC-1:HALF]));

  p_mask_hi_wr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADDR_W'(8'h08)) |=> $stable(mask_q[HALF-1:0]));
endmodule

bind intc_prio64 intc_prio64_chk #(
  .N_SRC(N_SRC), .LVL_W(LVL_W), .ADDR_W(ADDR_W), .VEC_W(VEC_W)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i), .err_o(err_o),
  .level_o(level_o), .vector_o(vector_o), .mask_q(mask_q)
);

// File: tb/test_intc_prio64.sv
module test_intc_prio64;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        err_o;
  logic [63:0] irq_i = '0;
  logic [7:0]  level_o, vector_o;

  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  intc_prio64 i_intc_prio64 (
    .clk_i, .rst_ni, .wr_i, .rd_i, .addr_i, .wdata_i, .rdata_o, .err_o,
    .irq_i, .level_o, .vector_o
  );

  // {irq, expected level, expected vector}; levels: s0=3 s5=7 s9=7 s40=2 s63=7 s20=0
  localparam logic [79:0] TBL [NVEC] = '{
    {64'h0,                                  8'd0, 8'd24},
    {64'h1,                                  8'd3, 8'd64},
    {64'h21,                                 8'd7, 8'd69},
    {64'h220,                                8'd7, 8'd73},
    {64'h8000_0000_0000_0220,                8'd7, 8'd127},
    {64'h0010_0000,                          8'd0, 8'd24},
    {64'h0000_0100_0010_0000,                8'd2, 8'd104},
    {64'h0000_0100_0000_0001,                8'd3, 8'd64}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    rd_i = 1'b1; addr_i = a;
    #1 d = rdata_o;
    rd_i = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R9 reset state
    chk("R9 level", 32'(level_o), 0);
    chk("R9 vector", 32'(vector_o), 24);
    chk("R9 err", 32'(err_o), 0);
    bus_rd(8'h08, d); chk("R9 mask hi", d, 32'hFFFF_FFFF);
    bus_rd(8'h0C, d); chk("R9 mask lo", d, 32'hFFFF_FFFF);
    bus_rd(8'h04, d); chk("R9 pend lo", d, 0);
    bus_rd(8'h7F, d); chk("R9 level byte", d, 0);
    bus_rd(8'hE0, d); chk("R9 ack vector", d, 24);

    // program priorities, open mask (R3, R6)
    bus_wr(8'h40, 3); bus_wr(8'h45, 7); bus_wr(8'h49, 7);
    bus_wr(8'h68, 2); bus_wr(8'h7F, 7); bus_wr(8'h54, 0);
    bus_wr(8'h08, 0); bus_wr(8'h0C, 0);
    bus_rd(8'h45, d); chk("R3 level readback", d, 7);
    bus_rd(8'h68, d); chk("R3 level readback", d, 2);

    // R2 R4 R5 vector table
    for (int i = 0; i < NVEC; i++) begin
      irq_i = TBL[i][79:16];
      settle();
      chk("R4/R5 table level", 32'(level_o), 32'(TBL[i][15:8]));
      chk("R4/R5 table vector", 32'(vector_o), 32'(TBL[i][7:0]));
    end

    // R1 pending readback
    irq_i = 64'h8000_0000_0000_0001;
    settle();
    bus_rd(8'h00, d); chk("R1 pend hi", d, 32'h8000_0000);
    bus_rd(8'h04, d); chk("R1 pend lo", d, 32'h1);

    // R7 pending writes ignored, no error
    bus_wr(8'h00, 32'hFFFF_FFFF);
    chk("R7 no err", 32'(err_o), 0);
    bus_rd(8'h00, d); chk("R7 pend unchanged", d, 32'h8000_0000);
    bus_rd(8'h04, d); chk("R7 pend unchanged", d, 32'h1);

    // R6 half-mask writes
    bus_wr(8'h08, 32'h8000_0000);  // mask source 63
    settle();
    chk("R6 masked top", 32'(vector_o), 64);
    bus_rd(8'h0C, d); chk("R6 lo untouched", d, 0);
    irq_i = 64'h21;
    bus_wr(8'h0C, 32'h20);          // mask source 5
    settle();
    chk("R2 masked src5 vector", 32'(vector_o), 64);
    chk("R2 masked src5 level", 32'(level_o), 3);
    bus_rd(8'h08, d); chk("R6 hi untouched", d, 32'h8000_0000);

    // R8 acknowledge and unlisted reads
    bus_rd(8'hE0, d); chk("R8 ack", d, 64);
    bus_rd(8'hE3, d); chk("R8 E3 zero", d, 0);
    bus_rd(8'h10, d); chk("R8 forced hi zero", d, 0);
    bus_rd(8'h14, d); chk("R8 forced lo zero", d, 0);
    bus_rd(8'h30, d); chk("R8 unlisted zero", d, 0);
    rd_i = 1'b0; addr_i = 8'h40; #1;
    chk("R8 idle rdata", rdata_o, 0);

    // R10 bad write: error pulse, no state change
    bus_wr(8'h10, 32'hFFFF_FFFF);
    chk("R10 err high", 32'(err_o), 1);
    @(negedge clk_i);
    chk("R10 err one cycle", 32'(err_o), 0);
    bus_rd(8'h08, d); chk("R10 mask intact", d, 32'h8000_0000);
    bus_wr(8'hE0, 32'h1);
    chk("R10 err on E0 write", 32'(err_o), 1);

    // R3 zero byte disables
    bus_wr(8'h0C, 0);
    irq_i = 64'h20;
    settle();
    chk("R3 src5 active", 32'(vector_o), 69);
    bus_wr(8'h45, 0);
    settle();
    chk("R3 disabled level", 32'(level_o), 0);
    chk("R3 disabled vector", 32'(vector_o), 24);

    // R11 one-edge latency after a priority write
    bus_wr(8'h45, 4);
    chk("R11 not yet", 32'(vector_o), 24);
    @(negedge clk_i);
    chk("R11 level next edge", 32'(level_o), 4);
    chk("R11 vector next edge", 32'(vector_o), 69);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule